// File: doc/BRIEF.md
# Register-write command stream packer

The block turns a stream of register-write requests into a command buffer made of two-word instructions. Each request carries a 20-bit register offset, a 32-bit value and a 32-bit mask. The packer reduces the mask to four byte enables and emits a direct write instruction. When full-width writes to one register follow each other, it merges them into a single indexed burst. The first such repeat rewrites the direct write that was already emitted into the burst form, in place. Later repeats add their value to the burst, keep its count word current, and keep a zero in the padding word whenever the burst ends on an odd word.

The buffer sits behind a word-addressed write port, one word per cycle. The packer does not read the buffer back. It holds the offset, kind, first value and count of the last instruction in registers. A finish request fills zeros up to the next 64-byte line, reports the tail as a byte offset, and starts a fresh buffer. A request that no longer fits is dropped and raises a sticky overflow flag.

Top module: `regstream_packer`

## Requirements
- R1: The byte-enable field is bits 23:20 of the upper instruction word. Enable bit i is set when any bit of mask byte i is set, so bit 0 covers mask bits 7:0 and bit 3 covers mask bits 31:24.
- R2: A direct write begins at the free word rounded up to an even address p. Word p receives the value first, then word p+1 receives {8'h01, byte enables, offset}. The free word becomes p+2.
- R3: A request merges only when all four byte enables are set and the last instruction is either a direct write to the same offset with all four enables set, or an indexed burst to the same offset. Every other request, including any request with a partial mask, becomes a direct write.
- R4: When a direct write at start address s is converted, the writes are, in order: s = 2 (count), s+1 = {8'h09, 4'h0, offset}, s+2 = old value, s+3 = new value. The free word becomes s+4.
- R5: Appending to a burst at s writes the value at the free word f, then the incremented count at s, then a zero at f+1 if f+1 is odd. The free word becomes f+1.
- R6: An empty buffer, after reset or after a finish, never merges, whatever the previous offset was.
- R7: If the free word exceeds the depth minus two when a request is accepted, the request is dropped with no buffer write, ready stays high, and overflow rises and stays set until reset.
- R8: Finish writes zeros at ascending addresses from the free word up to the next multiple of 16 words. In the cycle after the last zero, done is high for exactly one cycle and tail equals that boundary times 4. The buffer is then empty.
- R9: A finish issued when the free word is already a multiple of 16, including an empty buffer, makes no writes and raises done in the next cycle.
- R10: Ready is high only while no write is pending. The writes of an accepted request appear one per cycle, starting in the cycle after acceptance, and ready returns high once the last one is done.
- R11: After reset, ready is 1 and write enable, overflow, done and tail are all 0.
- R12: A finish request is taken only while ready is high and req_valid is low. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Packer can take a request or finish |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Value to write |
| req_mask | input | 32 | Bit mask, reduced to byte enables |
| finish_req | input | 1 | Close the buffer |
| mem_we | output | 1 | Buffer word write strobe |
| mem_addr | output | AW (6) | Buffer word address |
| mem_wdata | output | 32 | Buffer word data |
| overflow | output | 1 | Sticky: a request was dropped |
| done | output | 1 | One-cycle pulse when finish completes |
| tail_bytes | output | TW (9) | Byte offset of the buffer end |

## Verification
A wrong start pointer or count register does not show until the next merged request. That request writes its count word at the wrong address or with the wrong value, and this appears on the write port within one accepted request. A wrong free pointer shows at the address of the very next instruction or burst value, and again in the tail reported at finish. A stale last-instruction kind shows as a merge or a missed merge, so the bench covers repeats after partial masks, after a finish and across a padded odd end.

// File: rtl/regstream_pkg.sv
package regstream_pkg;
    localparam int OFS_W = 20;
    localparam logic [7:0] OP_DIRECT  = 8'h01;
    localparam logic [7:0] OP_INDEXED = 8'h09;
    localparam int LIST_N = 4;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_DFULL,
        LK_INDEX,
        LK_OTHER
    } last_kind_t;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_EMIT,
        PK_FILL
    } pk_mode_t;
endpackage

// File: rtl/rsp_byte_en.sv
module rsp_byte_en #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] mask,
    output logic [LANES-1:0]   be
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = |mask[8*g +: 8];
    end
endmodule

// File: rtl/rsp_merge_check.sv
module rsp_merge_check
    import regstream_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    localparam int PW = $clog2(DEPTH_WORDS + 1)
) (
    input  last_kind_t       kind,
    input  logic [OFS_W-1:0] last_off,
    input  logic [OFS_W-1:0] req_off,
    input  logic [3:0]       be,
    input  logic [PW-1:0]    free,
    output logic             do_convert,
    output logic             do_append,
    output logic             no_room
);
    localparam logic [PW-1:0] ROOM_LIMIT = PW'(DEPTH_WORDS - 2);

    logic mergeable;

    always_comb begin
        mergeable  = (&be) && (free != '0) && (last_off == req_off);
        no_room    = free > ROOM_LIMIT;
        do_convert = mergeable && (kind == LK_DFULL);
        do_append  = mergeable && (kind == LK_INDEX);
    end
endmodule

// File: rtl/regstream_packer.sv
module regstream_packer
    import regstream_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    parameter int LINE_BYTES  = 64,
    localparam int AW = $clog2(DEPTH_WORDS),
    localparam int PW = $clog2(DEPTH_WORDS + 1),
    localparam int TW = PW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [19:0]      req_offset,
    input  logic [31:0]      req_value,
    input  logic [31:0]      req_mask,
    input  logic             finish_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             overflow,
    output logic             done,
    output logic [TW-1:0]    tail_bytes
);
    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int CW = $clog2(LIST_N + 1);
    localparam int IW = $clog2(LIST_N);
    localparam logic [PW:0] LINE_MASK = (PW + 1)'(LINE_WORDS - 1);

    typedef struct packed {
        logic [PW-1:0]                 free;
        logic [PW-1:0]                 start;
        last_kind_t                    kind;
        logic [OFS_W-1:0]              off;
        logic [31:0]                   last_val;
        logic [31:0]                   count;
        logic [LIST_N-1:0][AW-1:0]     waddr;
        logic [LIST_N-1:0][31:0]       wdata;
        logic [CW-1:0]                 wlen;
        logic [CW-1:0]                 widx;
        pk_mode_t                      mode;
        logic [PW-1:0]                 fill_pos;
        logic [PW-1:0]                 fill_end;
        logic                          ovf;
        logic                          done;
        logic [TW-1:0]                 tail;
    } pk_state_t;

    pk_state_t s_q, s_d;

    logic [3:0]    be;
    logic          do_convert, do_append, no_room;
    logic [PW-1:0] p_even;
    logic [PW:0]   line_sum;
    logic [PW-1:0] aligned;

    rsp_byte_en #(.LANES(4)) u_be (
        .mask (req_mask),
        .be   (be)
    );

    rsp_merge_check #(.DEPTH_WORDS(DEPTH_WORDS)) u_merge (
        .kind       (s_q.kind),
        .last_off   (s_q.off),
        .req_off    (req_offset),
        .be         (be),
        .free       (s_q.free),
        .do_convert (do_convert),
        .do_append  (do_append),
        .no_room    (no_room)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        p_even   = s_q.free + PW'(s_q.free[0]);
        line_sum = {1'b0, s_q.free} + LINE_MASK;
        aligned  = PW'(line_sum & ~LINE_MASK);

        case (s_q.mode)
            PK_IDLE: begin
                if (req_valid) begin
                    if (no_room) begin
                        s_d.ovf = 1'b1;
                    end else if (do_convert) begin
                        s_d.waddr[0] = AW'(s_q.start);
                        s_d.wdata[0] = 32'd2;
                        s_d.waddr[1] = AW'(s_q.start + PW'(1));
                        s_d.wdata[1] = {OP_INDEXED, 4'h0, req_offset};
                        s_d.waddr[2] = AW'(s_q.start + PW'(2));
                        s_d.wdata[2] = s_q.last_val;
                        s_d.waddr[3] = AW'(s_q.start + PW'(3));
                        s_d.wdata[3] = req_value;
                        s_d.wlen     = CW'(4);
                        s_d.free     = s_q.start + PW'(4);
                        s_d.kind     = LK_INDEX;
                        s_d.count    = 32'd2;
                        s_d.widx     = '0;
                        s_d.mode     = PK_EMIT;
                    end else if (do_append) begin
                        s_d.waddr[0] = AW'(s_q.free);
                        s_d.wdata[0] = req_value;
                        s_d.waddr[1] = AW'(s_q.start);
                        s_d.wdata[1] = s_q.count + 32'd1;
                        s_d.waddr[2] = AW'(s_q.free + PW'(1));
                        s_d.wdata[2] = 32'd0;
                        s_d.wlen     = s_q.free[0] ? CW'(2) : CW'(3);
                        s_d.free     = s_q.free + PW'(1);
                        s_d.count    = s_q.count + 32'd1;
                        s_d.widx     = '0;
                        s_d.mode     = PK_EMIT;
                    end else begin
                        s_d.waddr[0] = AW'(p_even);
                        s_d.wdata[0] = req_value;
                        s_d.waddr[1] = AW'(p_even + PW'(1));
                        s_d.wdata[1] = {OP_DIRECT, be, req_offset};
                        s_d.wlen     = CW'(2);
                        s_d.start    = p_even;
                        s_d.free     = p_even + PW'(2);
                        s_d.kind     = (&be) ? LK_DFULL : LK_OTHER;
                        s_d.off      = req_offset;
                        s_d.last_val = req_value;
                        s_d.widx     = '0;
                        s_d.mode     = PK_EMIT;
                    end
                end else if (finish_req) begin
                    if (aligned == s_q.free) begin
                        s_d.done  = 1'b1;
                        s_d.tail  = {aligned, 2'b00};
                        s_d.free  = '0;
                        s_d.start = '0;
                        s_d.kind  = LK_NONE;
                    end else begin
                        s_d.fill_pos = s_q.free;
                        s_d.fill_end = aligned;
                        s_d.mode     = PK_FILL;
                    end
                end
            end
            PK_EMIT: begin
                s_d.widx = s_q.widx + CW'(1);
                if (s_d.widx == s_q.wlen) begin
                    s_d.mode = PK_IDLE;
                end
            end
            PK_FILL: begin
                s_d.fill_pos = s_q.fill_pos + PW'(1);
                if (s_d.fill_pos == s_q.fill_end) begin
                    s_d.mode  = PK_IDLE;
                    s_d.done  = 1'b1;
                    s_d.tail  = {s_q.fill_end, 2'b00};
                    s_d.free  = '0;
                    s_d.start = '0;
                    s_d.kind  = LK_NONE;
                end
            end
            default: s_d.mode = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ready  = (s_q.mode == PK_IDLE);
        mem_we     = (s_q.mode != PK_IDLE);
        mem_addr   = (s_q.mode == PK_FILL) ? AW'(s_q.fill_pos) : s_q.waddr[s_q.widx[IW-1:0]];
        mem_wdata  = (s_q.mode == PK_FILL) ? 32'd0 : s_q.wdata[s_q.widx[IW-1:0]];
        overflow   = s_q.ovf;
        done       = s_q.done;
        tail_bytes = s_q.tail;
    end
endmodule

// File: rtl/regstream_packer_chk.sv
module regstream_packer_chk #(
    parameter int DEPTH_WORDS = 64,
    parameter int LINE_BYTES  = 64,
    localparam int TW = $clog2(DEPTH_WORDS + 1) + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          mem_we,
    input logic          overflow,
    input logic          done,
    input logic [TW-1:0] tail_bytes
);
    localparam logic [TW-1:0] LINE_LOW = TW'(LINE_BYTES - 1);

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_TAIL_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n) done |-> ((tail_bytes & LINE_LOW) == '0)); // R8
    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !req_ready); // R10
    AST_WRITE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we) |-> $past(req_ready)); // R10
endmodule

bind regstream_packer regstream_packer_chk #(
    .DEPTH_WORDS (DEPTH_WORDS),
    .LINE_BYTES  (LINE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_we     (mem_we),
    .overflow   (overflow),
    .done       (done),
    .tail_bytes (tail_bytes)
);

// File: tb/regstream_packer_test.sv
`timescale 1ns/1ps
module regstream_packer_test;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int TW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [19:0]   req_offset = '0;
    logic [31:0]   req_value = '0;
    logic [31:0]   req_mask = '0;
    logic          finish_req = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          overflow;
    logic          done;
    logic [TW-1:0] tail_bytes;

    always #10 clk = ~clk;

    regstream_packer #(.DEPTH_WORDS(DEPTH), .LINE_BYTES(64)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_value(req_value), .req_mask(req_mask),
        .finish_req(finish_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .overflow(overflow), .done(done), .tail_bytes(tail_bytes)
    );

    typedef struct {
        int          addr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    int n_wr = 0;
    int n_done = 0;

    int          m_free, m_start, m_kind, m_cnt;
    logic [19:0] m_off;
    logic [31:0] m_val;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input int a, input logic [31:0] d, input string t);
        exp_t e;
        e.addr = a;
        e.data = d;
        e.tag  = t;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && done) n_done++;
        if (rst_n && mem_we) begin
            n_wr++;
            if (q.size() == 0) begin
                check(1'b0, "R10 unexpected write", {26'd0, mem_addr, mem_wdata}, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(mem_addr == AW'(e.addr) && mem_wdata == e.data, e.tag,
                      {26'd0, mem_addr, mem_wdata}, {26'd0, AW'(e.addr), e.data});
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [3:0] be_of(input logic [31:0] m);
        logic [3:0] b;
        for (int i = 0; i < 4; i++) b[i] = |m[8*i +: 8];
        return b;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        finish_req = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        m_free = 0; m_start = 0; m_kind = 0; m_cnt = 0; m_off = '0; m_val = '0;
        q.delete();
        tick();
    endtask

    task automatic send(input logic [19:0] off, input logic [31:0] val, input logic [31:0] mask,
                        input string tag, input bit with_fin);
        logic [3:0] be;
        bit rej;
        int p, wr0, dn0;
        be  = be_of(mask);
        rej = 1'b0;
        if (m_free > DEPTH - 2) begin
            rej = 1'b1;
        end else if (be == 4'hF && m_free != 0 && m_kind == 1 && m_off == off) begin
            push(m_start, 32'd2, {tag, " R4 count"});
            push(m_start + 1, {8'h09, 4'h0, off}, {tag, " R4 header"});
            push(m_start + 2, m_val, {tag, " R4 old value"});
            push(m_start + 3, val, {tag, " R4 new value"});
            m_free = m_start + 4; m_kind = 2; m_cnt = 2;
        end else if (be == 4'hF && m_free != 0 && m_kind == 2 && m_off == off) begin
            push(m_free, val, {tag, " R5 value"});
            m_cnt++;
            push(m_start, 32'(m_cnt), {tag, " R5 count"});
            m_free++;
            if (m_free % 2 == 1) push(m_free, 32'd0, {tag, " R5 pad"});
        end else begin
            p = m_free + (m_free % 2);
            push(p, val, {tag, " R2 value"});
            push(p + 1, {8'h01, be, off}, {tag, " R1 R2 header"});
            m_start = p; m_free = p + 2; m_off = off; m_val = val;
            m_kind = (be == 4'hF) ? 1 : 3;
        end
        while (!req_ready) tick();
        wr0 = n_wr; dn0 = n_done;
        req_valid = 1'b1; req_offset = off; req_value = val; req_mask = mask;
        finish_req = with_fin;
        tick();
        req_valid = 1'b0; finish_req = 1'b0;
        if (rej) begin
            check(req_ready == 1'b1, "R7 ready after drop", 64'(req_ready), 64'd1);
            check(overflow == 1'b1, "R7 overflow set", 64'(overflow), 64'd1);
            check(n_wr == wr0, "R7 no write on drop", 64'(n_wr - wr0), 64'd0);
        end else begin
            check(req_ready == 1'b0, "R10 ready low while writing", 64'(req_ready), 64'd0);
        end
        while (!req_ready) tick();
        check(q.size() == 0, "R10 all writes before ready", 64'(q.size()), 64'd0);
        if (with_fin) begin
            tick();
            check(n_done == dn0, "R12 finish ignored with valid", 64'(n_done - dn0), 64'd0);
            check(n_wr == wr0 + 2, "R12 no fill writes", 64'(n_wr - wr0), 64'd2);
        end
    endtask

    task automatic do_finish(input string tag);
        int al, wr0;
        al = ((m_free + 15) / 16) * 16;
        for (int a = m_free; a < al; a++) push(a, 32'd0, {tag, " R8 fill"});
        while (!req_ready) tick();
        wr0 = n_wr;
        finish_req = 1'b1;
        tick();
        finish_req = 1'b0;
        while (!done) tick();
        check(tail_bytes == TW'(al * 4), {tag, " R8 tail"}, 64'(tail_bytes), 64'(al * 4));
        check(q.size() == 0, {tag, " R8 fill before done"}, 64'(q.size()), 64'd0);
        if (al == m_free) check(n_wr == wr0, {tag, " R9 no writes"}, 64'(n_wr - wr0), 64'd0);
        tick();
        check(done == 1'b0, {tag, " R8 done one cycle"}, 64'(done), 64'd0);
        m_free = 0; m_kind = 0; m_start = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        check(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
        check(mem_we == 1'b0, "R11 we", 64'(mem_we), 64'd0);
        check(overflow == 1'b0, "R11 overflow", 64'(overflow), 64'd0);
        check(done == 1'b0, "R11 done", 64'(done), 64'd0);
        check(tail_bytes == '0, "R11 tail", 64'(tail_bytes), 64'd0);

        send(20'h00100, 32'hAAAA0001, 32'h00FF0000, "R1 one byte", 0);
        send(20'h00102, 32'h0000BEEF, 32'h00000000, "R1 no byte", 0);
        send(20'h00200, 32'h11110001, 32'hFFFFFFFF, "R2 full", 0);
        send(20'h00200, 32'h11110002, 32'hFFFFFFFF, "R4 convert", 0);
        send(20'h00200, 32'h11110003, 32'hFFFFFFFF, "R5 append odd", 0);
        send(20'h00300, 32'h22220001, 32'h01010101, "R2 new after odd", 0);
        send(20'h00300, 32'h22220002, 32'hFFFF0000, "R3 partial", 0);
        send(20'h00300, 32'h22220003, 32'hFFFFFFFF, "R3 after partial", 0);
        send(20'h00300, 32'h22220004, 32'hFFFFFFFF, "R4 convert 2", 0);
        send(20'h00300, 32'h22220005, 32'hFFFFFFFF, "R5 append 1", 0);
        send(20'h00300, 32'h22220006, 32'hFFFFFFFF, "R5 append 2", 0);
        send(20'h00301, 32'h33330001, 32'hFFFFFFFF, "R12 overlap", 1);
        do_finish("fin a");
        send(20'h00301, 32'h33330002, 32'hFFFFFFFF, "R6 empty no merge", 0);
        do_finish("fin b");
        do_finish("R9 empty");
        for (int i = 0; i < 8; i++)
            send(20'h00400 + 20'(i), 32'h44440000 + 32'(i), 32'hFFFFFFFF, "R2 line", 0);
        do_finish("R9 aligned");

        do_reset();
        for (int i = 0; i < 32; i++)
            send(20'h01000 + 20'(i), 32'h55550000 + 32'(i), 32'hFFFFFFFF, "R2 fill", 0);
        send(20'h02000, 32'h66660001, 32'hFFFFFFFF, "R7 drop", 0);
        send(20'h0101F, 32'h66660002, 32'hFFFFFFFF, "R7 drop merge", 0);
        check(overflow == 1'b1, "R7 sticky", 64'(overflow), 64'd1);
        do_finish("R9 full");
        check(overflow == 1'b1, "R7 sticky after finish", 64'(overflow), 64'd1);
        check(q.size() == 0, "R10 queue empty", 64'(q.size()), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule